// File: doc/BRIEF.md
# Infrared Mark/Space Duration Capture

This block times the marks and spaces of an already-demodulated infrared line. The line first passes through a short synchroniser. It then goes through an optional polarity flip and a programmable glitch filter. A measurement tick is formed by dividing the reference clock, and a width counter runs on that tick between qualifying transitions. When a measurement ends, the block writes one entry to a small receive FIFO. The entry carries a new-data-valid flag, the level the line held during the interval, and the upper bits of the width counter. The host drains the FIFO one entry per read strobe.

A three-state machine controls each capture. The states are `ST_OFF`, `ST_ARM` and `ST_MEASURE`.

- `ST_OFF` is held while the enable is low. In this state the counter and prescaler are held at zero.
- `ST_OFF -> ST_ARM` is taken when the enable rises.
- `ST_ARM -> ST_MEASURE` is taken on the first qualifying edge. This edge writes nothing.
- `ST_MEASURE -> ST_MEASURE` is taken on every further qualifying edge. Each such edge writes a width entry and restarts the counter.
- `ST_MEASURE -> ST_ARM` is taken when the counter would pass its all-ones value. This writes the timeout code.
- Any state goes to `ST_OFF` when the enable falls.

Status flags cover timeout, overrun, busy and service request. A shared interrupt output is raised when any flag is set and its enable is also set.

Top module: `irpw_capture`

## Requirements
- R1: The tick occurs once every `tick_div`+1 reference clocks, and the prescaler restarts at each qualifying edge. For an interval of N clocks between qualifying edges, the counter holds floor((N-1)/(`tick_div`+1)). The width field carries that count shifted right by two.
- R2: Each FIFO entry has the following layout.
  - Width in bits WID_W-1:0 (WID_W = CNT_W-2).
  - Line level in bit WID_W. This is the filtered, possibly inverted level held just before the ending edge.
  - New-data-valid flag in bit WID_W+1, set to 1.
- R3: `edge_sel` chooses which filtered transitions are qualifying: 00 none, 01 falling, 10 rising, 11 both. With 00 no measurement ever starts.
- R4: If a tick arrives while the counter is all ones, the block writes an entry with every bit set, sets `status[0]` and returns to `ST_ARM`.
- R5: The FIFO holds FIFO_DEPTH (default 8) entries and returns them in write order.
- R6: A write into a full FIFO is dropped and sets `status[1]`.
- R7: While the FIFO is empty, `rd_data` is all zeros, so its valid bit is clear. A `pop` while empty has no effect.
- R8: `status[4]` is high while the FIFO holds at least FIFO_DEPTH/2 entries. `irq` is high when any `status` bit is set together with the same bit of `irq_en`.
- R9: While `rx_en` is low, no entries are written, busy is low, and the timeout and overrun flags are cleared.
- R10: A filtered level change needs `glitch_len` consecutive reference clocks of a differing input, so shorter pulses are rejected. A `glitch_len` below 4 disables the filter.
- R11: `rx_invert` flips the line polarity before filtering and edge detection.
- R12: `status[2]` (busy) is high exactly while a measurement is running. `status[3]` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Capture enable; low clears sticky flags |
| rx_invert | input | 1 | Flip input polarity |
| edge_sel | input | 2 | Qualifying-edge select |
| tick_div | input | DIV_W | Prescaler divider (tick period = value+1 clocks) |
| glitch_len | input | FLT_W | Filter length in reference clocks (<4 disables) |
| irq_en | input | 5 | Interrupt enables, same positions as status |
| ir_in | input | 1 | Demodulated infrared line |
| pop | input | 1 | Read strobe, removes the head entry |
| rd_data | output | CNT_W | Head entry {valid, level, width} or zero |
| status | output | 5 | {service, 0, busy, overrun, timeout} |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The bench builds the block with CNT_W set to 10 and keeps the default FIFO depth of 8. The shorter counter means the timeout code and the return to the armed state are reached about a thousand clocks after the last edge, instead of a quarter million. The full depth of 8 makes the half-full service flag and the overrun on the ninth entry reachable within a few hundred clocks. Divider, filter length and edge mode remain runtime inputs, so every mode is tried on the same build.

// File: rtl/irpw_pkg.sv
`timescale 1ns/1ps
package irpw_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARM,
        ST_MEASURE
    } cap_state_e;

    localparam int STAT_TO   = 0;
    localparam int STAT_OVR  = 1;
    localparam int STAT_BUSY = 2;
    localparam int STAT_SVC  = 4;
    localparam int STAT_W    = 5;
endpackage

// File: rtl/irpw_prescaler.sv
`timescale 1ns/1ps
module irpw_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    assign tick = (phase_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase_q <= '0;
        else if (clr || tick)   phase_q <= '0;
        else                    phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/irpw_glitch_filter.sv
`timescale 1ns/1ps
module irpw_glitch_filter #(
    parameter int FLT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             invert,
    input  logic [FLT_W-1:0] min_len,
    output logic             level
);
    localparam logic [FLT_W-1:0] MIN_ACTIVE = FLT_W'(4);

    logic [SYNC_N-1:0] sync_q;
    logic              raw_lvl;
    logic              bypass;
    logic [FLT_W-1:0]  run_q;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_N-2:0], line_in};
            end
        end
    endgenerate

    assign raw_lvl = sync_q[SYNC_N-1] ^ invert;
    assign bypass  = (min_len < MIN_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b0;
            run_q <= '0;
        end else if (bypass) begin
            level <= raw_lvl;
            run_q <= '0;
        end else if (raw_lvl == level) begin
            run_q <= '0;
        end else if (run_q >= min_len - FLT_W'(1)) begin
            level <= raw_lvl;
            run_q <= '0;
        end else begin
            run_q <= run_q + FLT_W'(1);
        end
    end
endmodule

// File: rtl/irpw_fifo.sv
`timescale 1ns/1ps
module irpw_fifo #(
    parameter int DW    = 17,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/irpw_capture.sv
`timescale 1ns/1ps
module irpw_capture
    import irpw_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FLT_W      = 16,
    parameter int CNT_W      = 18,
    parameter int FIFO_DEPTH = 8,
    localparam int WID_W     = CNT_W - 2,
    localparam int ENT_W     = WID_W + 2,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_invert,
    input  logic [1:0]        edge_sel,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic [FLT_W-1:0]  glitch_len,
    input  logic [4:0]        irq_en,
    input  logic              ir_in,
    input  logic              pop,
    output logic [ENT_W-1:0]  rd_data,
    output logic [4:0]        status,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cap_state_e        state_q, state_d;
    edge_mode_e        mode;
    logic              flt, flt_d, rise, fall, hit;
    logic              tick, presc_clr;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_clr, cnt_inc;
    logic              push_req, set_to;
    logic [WID_W:0]    push_data;
    logic [WID_W:0]    fifo_head;
    logic [LW-1:0]     fifo_level;
    logic              fifo_full, fifo_empty;
    logic              to_q, ovr_q;

    irpw_glitch_filter #(.FLT_W(FLT_W), .SYNC_N(2)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_in(ir_in), .invert(rx_invert),
        .min_len(glitch_len), .level(flt)
    );

    irpw_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .div(tick_div), .tick(tick)
    );

    irpw_fifo #(.DW(WID_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_req), .push_data(push_data),
        .pop(pop), .head(fifo_head), .level(fifo_level),
        .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_d <= 1'b0;
        else        flt_d <= flt;
    end

    assign rise = flt && !flt_d;
    assign fall = !flt && flt_d;
    assign mode = edge_mode_e'(edge_sel);

    always_comb begin
        unique case (mode)
            EDGE_NONE: hit = 1'b0;
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            EDGE_BOTH: hit = rise || fall;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs and transitions
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        presc_clr = 1'b0;
        push_req  = 1'b0;
        set_to    = 1'b0;
        push_data = '0;
        unique case (state_q)
            ST_OFF: begin
                cnt_clr   = 1'b1;
                presc_clr = 1'b1;
                if (rx_en) state_d = ST_ARM;
            end
            ST_ARM: begin
                cnt_clr   = 1'b1;
                presc_clr = 1'b1;
                if (!rx_en)   state_d = ST_OFF;
                else if (hit) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!rx_en) begin
                    cnt_clr   = 1'b1;
                    presc_clr = 1'b1;
                    state_d   = ST_OFF;
                end else if (hit) begin
                    push_req  = 1'b1;
                    push_data = {flt_d, cnt_q[CNT_W-1:2]};
                    cnt_clr   = 1'b1;
                    presc_clr = 1'b1;
                end else if (tick && cnt_q == CNT_MAX) begin
                    push_req  = 1'b1;
                    push_data = '1;
                    set_to    = 1'b1;
                    cnt_clr   = 1'b1;
                    presc_clr = 1'b1;
                    state_d   = ST_ARM;
                end else if (tick) begin
                    cnt_inc = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else if (!rx_en) begin
            to_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (set_to)                to_q  <= 1'b1;
            if (push_req && fifo_full) ovr_q <= 1'b1;
        end
    end

    assign rd_data = fifo_empty ? '0 : {1'b1, fifo_head};

    always_comb begin
        status           = '0;
        status[STAT_TO]   = to_q;
        status[STAT_OVR]  = ovr_q;
        status[STAT_BUSY] = (state_q == ST_MEASURE);
        status[STAT_SVC]  = (fifo_level >= LW'(FIFO_DEPTH / 2));
    end

    assign irq = |(status & irq_en);
endmodule

// File: rtl/irpw_capture_chk.sv
`timescale 1ns/1ps
module irpw_capture_chk #(
    parameter int WID_W      = 16,
    parameter int ENT_W      = 18,
    parameter int FIFO_DEPTH = 8,
    parameter int LW         = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic [4:0]       status,
    input logic [ENT_W-1:0] rd_data,
    input logic             push_req,
    input logic [WID_W:0]   push_data,
    input logic             fifo_full,
    input logic [LW-1:0]    fifo_level
);
    AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(push_req && (&push_data))) else $error("timeout flag without code"); // R4

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full && rx_en) |=> status[1]) else $error("overrun not flagged"); // R6

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(FIFO_DEPTH)) else $error("fifo level above depth"); // R5

    AST_EMPTY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !rd_data[ENT_W-1]) else $error("valid bit on empty"); // R7

    AST_SVC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> (fifo_level >= LW'(FIFO_DEPTH / 2))) else $error("service flag early"); // R8

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en)) |-> !push_req) else $error("write while disabled"); // R9

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !status[2]) else $error("busy while disabled"); // R12
endmodule

bind irpw_capture irpw_capture_chk #(
    .WID_W(WID_W), .ENT_W(ENT_W), .FIFO_DEPTH(FIFO_DEPTH), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .status(status),
    .rd_data(rd_data), .push_req(push_req), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_level(fifo_level)
);

// File: tb/irpw_capture_test.sv
`timescale 1ns/1ps
module irpw_capture_test;
    localparam int CNT_W = 10;
    localparam int WID_W = CNT_W - 2;
    localparam int ENT_W = CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_en = 1'b0;
    logic             rx_invert = 1'b0;
    logic [1:0]       edge_sel = 2'b00;
    logic [15:0]      tick_div = '0;
    logic [15:0]      glitch_len = '0;
    logic [4:0]       irq_en = '0;
    logic             ir_in = 1'b0;
    logic             pop = 1'b0;
    logic [ENT_W-1:0] rd_data;
    logic [4:0]       status;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irpw_capture #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_invert(rx_invert),
        .edge_sel(edge_sel), .tick_div(tick_div), .glitch_len(glitch_len),
        .irq_en(irq_en), .ir_in(ir_in), .pop(pop), .rd_data(rd_data),
        .status(status), .irq(irq)
    );

    function automatic logic [ENT_W-1:0] mk(input logic lvl, input int w);
        return {1'b1, lvl, WID_W'(w)};
    endfunction

    function automatic int expw(input int n, input int div);
        return ((n - 1) / (div + 1)) >> 2;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle(input int hold);
        ir_in = ~ir_in;
        wait_clk(hold);
    endtask

    task automatic pop_chk(input string req, input logic [ENT_W-1:0] exp);
        chk(req, "entry", rd_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic arm(input logic [1:0] sel, input int div, input logic inv, input int glen);
        rx_en = 1'b0;
        @(negedge clk);
        edge_sel   = sel;
        tick_div   = 16'(div);
        rx_invert  = inv;
        glitch_len = 16'(glen);
        wait_clk(6);
        rx_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic disarm();
        rx_en = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_reset();
        irq_en = 5'b11111;
        @(negedge clk);
        chk("R12", "status after reset", status, 5'b00000);
        chk("R7", "rd_data after reset", rd_data, '0);
        chk("R8", "irq after reset", irq, 1'b0);
        irq_en = '0;
    endtask

    task automatic t_both_timeout();
        arm(2'b11, 0, 1'b0, 0);
        toggle(41); toggle(81); toggle(21); toggle(20);
        chk("R12", "busy mid-measure", status, 5'b00100);
        pop_chk("R1", mk(1'b1, expw(41, 0)));
        pop_chk("R2", mk(1'b0, expw(81, 0)));
        pop_chk("R5", mk(1'b1, expw(21, 0)));
        wait_clk(1100);
        chk("R4", "timeout status", status, 5'b00001);
        pop_chk("R4", {ENT_W{1'b1}});
        chk("R7", "empty after drain", rd_data, '0);
        disarm();
        chk("R9", "flags cleared when disabled", status, 5'b00000);
    endtask

    task automatic t_divider();
        arm(2'b11, 3, 1'b0, 0);
        toggle(161); toggle(20);
        disarm();
        pop_chk("R1", mk(1'b1, expw(161, 3)));
        chk("R1", "single entry", rd_data, '0);
    endtask

    task automatic t_fall_only();
        arm(2'b01, 0, 1'b0, 0);
        toggle(50); toggle(30); toggle(70); toggle(20);
        disarm();
        pop_chk("R3", mk(1'b1, expw(100, 0)));
        chk("R3", "falling mode one entry", rd_data, '0);
    endtask

    task automatic t_none();
        arm(2'b00, 0, 1'b0, 0);
        for (int i = 0; i < 4; i++) toggle(30);
        wait_clk(10);
        chk("R3", "none mode idle", status, 5'b00000);
        chk("R3", "none mode no entry", rd_data, '0);
        disarm();
    endtask

    task automatic t_invert();
        arm(2'b11, 0, 1'b1, 0);
        toggle(41); toggle(20);
        disarm();
        pop_chk("R11", mk(1'b0, expw(41, 0)));
        rx_invert = 1'b0;
        wait_clk(6);
    endtask

    task automatic t_overrun();
        arm(2'b11, 0, 1'b0, 0);
        for (int i = 0; i < 10; i++) begin
            ir_in = ~ir_in;
            if (i == 4) begin
                wait_clk(10);
                chk("R8", "service at half", status, 5'b10100);
                irq_en = 5'b10000;
                #1;
                chk("R8", "irq service enabled", irq, 1'b1);
                irq_en = 5'b00000;
                #1;
                chk("R8", "irq all masked", irq, 1'b0);
                wait_clk(11);
            end else begin
                wait_clk(21);
            end
        end
        chk("R6", "overrun status", status, 5'b10110);
        irq_en = 5'b00010;
        #1;
        chk("R8", "irq overrun enabled", irq, 1'b1);
        irq_en = '0;
        for (int k = 1; k <= 8; k++)
            pop_chk("R6", mk(logic'(k % 2), expw(21, 0)));
        chk("R7", "empty after eight", rd_data, '0);
        pop = 1'b1; @(negedge clk); pop = 1'b0;
        chk("R7", "pop on empty", rd_data, '0);
        chk("R8", "service drops", status, 5'b00110);
        disarm();
        chk("R9", "overrun cleared", status, 5'b00000);
    endtask

    task automatic t_filter();
        arm(2'b11, 0, 1'b0, 8);
        toggle(3); toggle(30);
        chk("R10", "short pulse rejected", status, 5'b00000);
        toggle(61); toggle(20); toggle(3); toggle(40); toggle(20); toggle(30);
        pop_chk("R10", mk(1'b1, expw(61, 0)));
        pop_chk("R10", mk(1'b0, expw(63, 0)));
        pop_chk("R10", mk(1'b1, expw(20, 0)));
        chk("R10", "no glitch entries", rd_data, '0);
        disarm();
    endtask

    task automatic t_filter_off();
        arm(2'b11, 0, 1'b0, 3);
        toggle(2); toggle(20);
        disarm();
        pop_chk("R10", mk(1'b1, expw(2, 0)));
        for (int i = 0; i < 4; i++) toggle(25);
        chk("R9", "no entry while disabled", rd_data, '0);
        chk("R9", "status while disabled", status, 5'b00000);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_both_timeout();
        t_divider();
        t_fall_only();
        t_none();
        t_invert();
        t_overrun();
        t_filter();
        t_filter_off();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule